// File: doc/BRIEF.md
# Out-of-Order Response Completion Tracker

This block follows message descriptors that have been transmitted and are still waiting for responses from the link. Each descriptor covers a message of up to 4096 bytes, sent as 256-byte segments, and every segment gets its own response. Responses may come back in any order, across descriptors and within one. The tracker keeps a circular table of up to 16 outstanding descriptors. A descriptor is assigned its tag in issue order. Its entry records a completion code as soon as its responses allow it to finish, even when older descriptors are still pending.

A descriptor finishes when every segment has been answered, or when its response timer expires. A segment answered with RETRY is reported on a retry port so that the transmitter can resend only that segment, with its byte offset and length already computed. This happens only while the descriptor's retry budget lasts. Once the budget is spent, a RETRY closes the segment with a failure code. The completion pointer moves forward only over a contiguous run of finished descriptors starting at the oldest one, and it pulses the interrupt once for each move. Response and timeout handling take priority: while either happens, no new descriptor is accepted.

Top module: `otr_tracker`

## Requirements
- R1: After reset the completion pointer is 0, the interrupt and retry valid are low, issue ready is high and no tag is busy.
- R2: Accepted descriptors get consecutive tags modulo 16, starting at the completion pointer, and issue_tag_o shows the next tag. Issue ready is low while 16 descriptors are outstanding.
- R3: Issue ready is low in any cycle where a response is presented, or where some entry's timeout expires at the coming edge.
- R4: Response status encoding is 0 DONE, 1 ERROR, 2 RETRY. A descriptor of length L (1..4096) has ceil(L/256) segments. It finishes when every segment has been consumed by a DONE, an ERROR or an exhausted RETRY.
- R5: A RETRY is granted while the descriptor's used retries are below retry_limit_i. The segment then stays pending, and one cycle later retry_valid_o pulses for one cycle with the tag, the segment, offset = segment×256, and length 256, or L − offset for the last segment. Otherwise the segment is consumed.
- R6: With tmo_limit_i = T > 0, a descriptor finishes with code 3 once T consecutive edges pass without a response to it. The count starts at issue and restarts on each accepted response. T = 0 disables the timeout.
- R7: The completion code is the highest value seen among 0 OK, 1 ERROR (an ERROR response), 2 RETRY exhausted and 3 timeout.
- R8: The status query (stat_tag_i) shows a descriptor done, with its code, in the cycle after it finishes, regardless of older outstanding descriptors.
- R9: A descriptor that finishes while an older one is outstanding moves neither the pointer nor the interrupt.
- R10: One edge after the oldest descriptor is done, the pointer jumps past the entire contiguous done run, those tags become not busy, and irq_o is high for exactly one cycle.
- R11: Responses to tags that are not busy or already done change no state and raise no retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retry_limit_i | input | 4 | Retries allowed per descriptor |
| tmo_limit_i | input | 16 | Response timeout in cycles, 0 disables |
| issue_valid_i | input | 1 | Descriptor transmitted this cycle |
| issue_len_i | input | 13 | Message length in bytes (1..4096) |
| issue_ready_o | output | 1 | Descriptor can be accepted |
| issue_tag_o | output | 4 | Tag given to the next accepted descriptor |
| rsp_valid_i | input | 1 | Segment response present |
| rsp_tag_i | input | 4 | Tag of the response |
| rsp_seg_i | input | 4 | Segment number of the response |
| rsp_status_i | input | 2 | 0 DONE, 1 ERROR, 2 RETRY |
| retry_valid_o | output | 1 | Segment resend request |
| retry_tag_o | output | 4 | Tag to resend |
| retry_seg_o | output | 4 | Segment to resend |
| retry_offset_o | output | 13 | Byte offset of the segment |
| retry_len_o | output | 9 | Byte length of the segment |
| cmpl_ptr_o | output | 4 | Oldest outstanding tag |
| irq_o | output | 1 | One-cycle pulse on pointer advance |
| stat_tag_i | input | 4 | Tag to query |
| stat_busy_o | output | 1 | Queried tag is outstanding |
| stat_done_o | output | 1 | Queried tag has finished |
| stat_code_o | output | 2 | Completion code of queried tag |

## Verification
On every cycle the assertions check four things: issue is blocked whenever a response is present, a finished entry stays finished and busy until it retires, the pointer never moves without an interrupt, and a retry length always lies within one segment. Only the bench scenarios can show the arithmetic and the ordering. This covers the retry offsets and last-segment lengths for each segment, the exact timeout cycle with and without a restarting response, the code ranking, and the pointer staying put across fourteen out-of-order completions and then jumping fifteen places at once.

// File: rtl/otr_pkg.sv
package otr_pkg;
  typedef enum logic [1:0] {
    RSP_DONE  = 2'd0,
    RSP_ERROR = 2'd1,
    RSP_RETRY = 2'd2
  } rsp_e;

  // ordered by severity: the larger value wins
  typedef enum logic [1:0] {
    CC_OK        = 2'd0,
    CC_ERROR     = 2'd1,
    CC_RETRY_EXH = 2'd2,
    CC_TIMEOUT   = 2'd3
  } cc_e;

  function automatic cc_e cc_worst(cc_e a, cc_e b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/otr_seg_calc.sv
module otr_seg_calc #(
  parameter int SEG_W  = 4,
  parameter int SEG_SH = 8,
  parameter int LEN_W  = SEG_W + SEG_SH + 1,
  localparam int SEG_LEN_W = SEG_SH + 1,
  localparam int SEG_CNT_W = SEG_W + 1
) (
  input  logic [SEG_W-1:0]     seg_i,
  input  logic [LEN_W-1:0]     len_i,
  output logic [SEG_CNT_W-1:0] nsegs_o,
  output logic [LEN_W-1:0]     offset_o,
  output logic [SEG_LEN_W-1:0] seg_len_o
);
  localparam int SEG_BYTES = 1 << SEG_SH;

  logic [LEN_W-1:0] last_idx;

  always_comb begin
    last_idx  = (len_i - LEN_W'(1)) >> SEG_SH;
    nsegs_o   = SEG_CNT_W'(last_idx) + SEG_CNT_W'(1);
    offset_o  = LEN_W'({seg_i, {SEG_SH{1'b0}}});
    seg_len_o = (LEN_W'(seg_i) == last_idx) ? SEG_LEN_W'(len_i - offset_o)
                                            : SEG_LEN_W'(SEG_BYTES);
  end
endmodule

// File: rtl/otr_entry.sv
module otr_entry
  import otr_pkg::*;
#(
  parameter int SEG_CNT_W = 5,
  parameter int LEN_W     = 13,
  parameter int RTRY_W    = 4,
  parameter int TMO_W     = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 alloc_i,
  input  logic [SEG_CNT_W-1:0] alloc_segs_i,
  input  logic [LEN_W-1:0]     alloc_len_i,
  input  logic                 free_i,
  input  logic                 rsp_hit_i,
  input  rsp_e                 rsp_status_i,
  input  logic [RTRY_W-1:0]    retry_limit_i,
  input  logic [TMO_W-1:0]     tmo_limit_i,
  output logic                 busy_o,
  output logic                 done_o,
  output cc_e                  code_o,
  output logic [LEN_W-1:0]     len_o,
  output logic                 retry_go_o,
  output logic                 tmo_fire_o
);
  logic                 busy_q, done_q;
  logic [SEG_CNT_W-1:0] rem_q;
  logic [RTRY_W-1:0]    rtry_q;
  logic [TMO_W-1:0]     tmr_q;
  cc_e                  code_q;
  logic [LEN_W-1:0]     len_q;

  logic active, hit;
  cc_e  seg_cc;

  always_comb begin
    active     = busy_q && !done_q;
    hit        = rsp_hit_i && active;
    retry_go_o = hit && (rsp_status_i == RSP_RETRY) && (rtry_q < retry_limit_i);
    tmo_fire_o = active && !hit && (tmo_limit_i != '0) &&
                 (({1'b0, tmr_q} + (TMO_W+1)'(1)) == {1'b0, tmo_limit_i});
    unique case (rsp_status_i)
      RSP_DONE:  seg_cc = CC_OK;
      RSP_RETRY: seg_cc = CC_RETRY_EXH;
      default:   seg_cc = CC_ERROR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rem_q  <= '0;
      rtry_q <= '0;
      tmr_q  <= '0;
      code_q <= CC_OK;
      len_q  <= '0;
    end else if (alloc_i) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      rem_q  <= alloc_segs_i;
      rtry_q <= '0;
      tmr_q  <= '0;
      code_q <= CC_OK;
      len_q  <= alloc_len_i;
    end else if (free_i) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (active) begin
      if (hit) begin
        tmr_q <= '0;
        if (retry_go_o) begin
          rtry_q <= rtry_q + RTRY_W'(1);
        end else begin
          rem_q  <= rem_q - SEG_CNT_W'(1);
          code_q <= cc_worst(code_q, seg_cc);
          if (rem_q == SEG_CNT_W'(1)) done_q <= 1'b1;
        end
      end else begin
        tmr_q <= tmr_q + TMO_W'(1);
        if (tmo_fire_o) begin
          done_q <= 1'b1;
          code_q <= CC_TIMEOUT;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign code_o = code_q;
  assign len_o  = len_q;

  assert_done_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !free_i && !alloc_i) |=> (done_q && $stable(code_q)));

  assert_done_needs_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> busy_q);
endmodule

// File: rtl/otr_retire.sv
module otr_retire #(
  parameter int TAG_W = 4,
  localparam int N     = 1 << TAG_W,
  localparam int CNT_W = TAG_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     done_i,
  input  logic             alloc_i,
  output logic [TAG_W-1:0] head_o,
  output logic [TAG_W-1:0] tail_o,
  output logic             full_o,
  output logic [N-1:0]     free_o,
  output logic             irq_o
);
  logic [TAG_W-1:0] head_q;
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;
  logic [CNT_W-1:0] run;
  logic [TAG_W-1:0] idx;
  logic             go;

  // contiguous done run from the oldest entry, retired in one edge
  always_comb begin
    run    = '0;
    go     = 1'b1;
    free_o = '0;
    idx    = head_q;
    for (int k = 0; k < N; k++) begin
      idx = head_q + TAG_W'(k);
      if (go && (CNT_W'(k) < cnt_q) && done_i[idx]) begin
        run         = run + CNT_W'(1);
        free_o[idx] = 1'b1;
      end else begin
        go = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      head_q <= head_q + TAG_W'(run);
      cnt_q  <= cnt_q + CNT_W'(alloc_i) - run;
      irq_q  <= (run != '0);
    end
  end

  assign head_o = head_q;
  assign tail_o = head_q + cnt_q[TAG_W-1:0];
  assign full_o = cnt_q[TAG_W];
  assign irq_o  = irq_q;

  assert_count_cap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(N));

  assert_no_alloc_when_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q[TAG_W] |-> !alloc_i);

  assert_ptr_move_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_q != $past(head_q)) |-> irq_q);
endmodule

// File: rtl/otr_tracker.sv
module otr_tracker
  import otr_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int SEG_W  = 4,
  parameter int SEG_SH = 8,
  parameter int RTRY_W = 4,
  parameter int TMO_W  = 16,
  localparam int N         = 1 << TAG_W,
  localparam int LEN_W     = SEG_W + SEG_SH + 1,
  localparam int SEG_LEN_W = SEG_SH + 1,
  localparam int SEG_CNT_W = SEG_W + 1,
  localparam int SEG_BYTES = 1 << SEG_SH
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [RTRY_W-1:0]    retry_limit_i,
  input  logic [TMO_W-1:0]     tmo_limit_i,
  input  logic                 issue_valid_i,
  input  logic [LEN_W-1:0]     issue_len_i,
  output logic                 issue_ready_o,
  output logic [TAG_W-1:0]     issue_tag_o,
  input  logic                 rsp_valid_i,
  input  logic [TAG_W-1:0]     rsp_tag_i,
  input  logic [SEG_W-1:0]     rsp_seg_i,
  input  logic [1:0]           rsp_status_i,
  output logic                 retry_valid_o,
  output logic [TAG_W-1:0]     retry_tag_o,
  output logic [SEG_W-1:0]     retry_seg_o,
  output logic [LEN_W-1:0]     retry_offset_o,
  output logic [SEG_LEN_W-1:0] retry_len_o,
  output logic [TAG_W-1:0]     cmpl_ptr_o,
  output logic                 irq_o,
  input  logic [TAG_W-1:0]     stat_tag_i,
  output logic                 stat_busy_o,
  output logic                 stat_done_o,
  output logic [1:0]           stat_code_o
);
  logic [N-1:0]     busy_v, done_v, free_v, retry_go_v, tmo_fire_v, alloc_v;
  cc_e              code_a [N];
  logic [LEN_W-1:0] len_a  [N];
  logic [TAG_W-1:0] tail;
  logic             full, issue_fire;
  rsp_e             status;

  logic [SEG_CNT_W-1:0] iss_nsegs, rty_nsegs_unused;
  logic [LEN_W-1:0]     iss_off_unused, rty_off;
  logic [SEG_LEN_W-1:0] iss_len_unused, rty_len;

  assign status        = rsp_e'(rsp_status_i);
  assign issue_ready_o = !full && !rsp_valid_i && !(|tmo_fire_v);
  assign issue_fire    = issue_valid_i && issue_ready_o;
  assign issue_tag_o   = tail;

  otr_seg_calc #(.SEG_W(SEG_W), .SEG_SH(SEG_SH), .LEN_W(LEN_W)) u_iss_calc (
    .seg_i     ('0),
    .len_i     (issue_len_i),
    .nsegs_o   (iss_nsegs),
    .offset_o  (iss_off_unused),
    .seg_len_o (iss_len_unused)
  );

  otr_seg_calc #(.SEG_W(SEG_W), .SEG_SH(SEG_SH), .LEN_W(LEN_W)) u_rty_calc (
    .seg_i     (rsp_seg_i),
    .len_i     (len_a[rsp_tag_i]),
    .nsegs_o   (rty_nsegs_unused),
    .offset_o  (rty_off),
    .seg_len_o (rty_len)
  );

  otr_retire #(.TAG_W(TAG_W)) u_retire (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (done_v),
    .alloc_i (issue_fire),
    .head_o  (cmpl_ptr_o),
    .tail_o  (tail),
    .full_o  (full),
    .free_o  (free_v),
    .irq_o   (irq_o)
  );

  for (genvar g = 0; g < N; g++) begin : g_ent
    assign alloc_v[g] = issue_fire && (tail == TAG_W'(g));

    otr_entry #(
      .SEG_CNT_W (SEG_CNT_W),
      .LEN_W     (LEN_W),
      .RTRY_W    (RTRY_W),
      .TMO_W     (TMO_W)
    ) u_ent (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .alloc_i       (alloc_v[g]),
      .alloc_segs_i  (iss_nsegs),
      .alloc_len_i   (issue_len_i),
      .free_i        (free_v[g]),
      .rsp_hit_i     (rsp_valid_i && (rsp_tag_i == TAG_W'(g))),
      .rsp_status_i  (status),
      .retry_limit_i (retry_limit_i),
      .tmo_limit_i   (tmo_limit_i),
      .busy_o        (busy_v[g]),
      .done_o        (done_v[g]),
      .code_o        (code_a[g]),
      .len_o         (len_a[g]),
      .retry_go_o    (retry_go_v[g]),
      .tmo_fire_o    (tmo_fire_v[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      retry_valid_o  <= 1'b0;
      retry_tag_o    <= '0;
      retry_seg_o    <= '0;
      retry_offset_o <= '0;
      retry_len_o    <= '0;
    end else begin
      retry_valid_o <= |retry_go_v;
      if (|retry_go_v) begin
        retry_tag_o    <= rsp_tag_i;
        retry_seg_o    <= rsp_seg_i;
        retry_offset_o <= rty_off;
        retry_len_o    <= rty_len;
      end
    end
  end

  assign stat_busy_o = busy_v[stat_tag_i];
  assign stat_done_o = done_v[stat_tag_i];
  assign stat_code_o = code_a[stat_tag_i];

  assert_rsp_blocks_issue_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |-> !issue_ready_o);

  assert_retry_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(retry_go_v));

  assert_retry_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_valid_o |-> (retry_len_o != '0 && retry_len_o <= SEG_LEN_W'(SEG_BYTES)));
endmodule

// File: tb/tb_otr_tracker.sv
`timescale 1ns/1ps
module tb_otr_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  retry_limit = 4'd0;
  logic [15:0] tmo_limit = 16'd0;
  logic        issue_valid = 1'b0;
  logic [12:0] issue_len = '0;
  logic        issue_ready;
  logic [3:0]  issue_tag;
  logic        rsp_valid = 1'b0;
  logic [3:0]  rsp_tag = '0;
  logic [3:0]  rsp_seg = '0;
  logic [1:0]  rsp_status = '0;
  logic        retry_valid;
  logic [3:0]  retry_tag, retry_seg;
  logic [12:0] retry_offset;
  logic [8:0]  retry_len;
  logic [3:0]  cmpl_ptr;
  logic        irq;
  logic [3:0]  stat_tag = '0;
  logic        stat_busy, stat_done;
  logic [1:0]  stat_code;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  otr_tracker dut (
    .clk_i(clk), .rst_ni(rst_n), .retry_limit_i(retry_limit), .tmo_limit_i(tmo_limit),
    .issue_valid_i(issue_valid), .issue_len_i(issue_len), .issue_ready_o(issue_ready),
    .issue_tag_o(issue_tag), .rsp_valid_i(rsp_valid), .rsp_tag_i(rsp_tag),
    .rsp_seg_i(rsp_seg), .rsp_status_i(rsp_status), .retry_valid_o(retry_valid),
    .retry_tag_o(retry_tag), .retry_seg_o(retry_seg), .retry_offset_o(retry_offset),
    .retry_len_o(retry_len), .cmpl_ptr_o(cmpl_ptr), .irq_o(irq), .stat_tag_i(stat_tag),
    .stat_busy_o(stat_busy), .stat_done_o(stat_done), .stat_code_o(stat_code)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int nsegs(input int len);
    return (len - 1) / 256 + 1;
  endfunction

  task automatic peek(input int tag, output int busy, output int done, output int code);
    stat_tag = tag[3:0];
    #1;
    busy = int'(stat_busy);
    done = int'(stat_done);
    code = int'(stat_code);
  endtask

  task automatic issue(input int len, input int exp_tag);
    chk("R2 issue tag", int'(issue_tag), exp_tag);
    chk("R2 issue ready", int'(issue_ready), 1);
    issue_valid = 1'b1;
    issue_len = len[12:0];
    step();
    issue_valid = 1'b0;
  endtask

  task automatic rsp(input int tag, input int seg, input int st);
    rsp_valid = 1'b1;
    rsp_tag = tag[3:0];
    rsp_seg = seg[3:0];
    rsp_status = st[1:0];
    step();
    rsp_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int b, d, c, tg, ln;
    int lens [16];
    repeat (3) step();
    // R1 reset state
    chk("R1 cmpl_ptr", int'(cmpl_ptr), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 retry_valid", int'(retry_valid), 0);
    chk("R1 issue_ready", int'(issue_ready), 1);
    for (int t = 0; t < 16; t++) begin
      peek(t, b, d, c);
      chk("R1 tag idle", b, 0);
    end
    rst_n = 1'b1;
    step();

    // in-order completion, pointer 0 -> 3
    for (int k = 0; k < 3; k++) issue(100, k);
    for (int k = 0; k < 3; k++) begin
      rsp(k, 0, 0);
      chk("R10 irq low on done edge", int'(irq), 0);
      step();
      chk("R10 pointer in order", int'(cmpl_ptr), k + 1);
      chk("R10 irq pulse", int'(irq), 1);
    end
    step();
    chk("R10 irq one cycle", int'(irq), 0);

    // fill 16 descriptors from pointer 3
    for (int k = 0; k < 16; k++) begin
      lens[k] = 1 + k * 250;
      issue(lens[k], (3 + k) % 16);
    end
    chk("R2 full blocks issue", int'(issue_ready), 0);

    // finish positions 14..1 out of order
    for (int k = 14; k >= 1; k--) begin
      tg = (3 + k) % 16;
      for (int s = 0; s < nsegs(lens[k]); s++) begin
        if (s == nsegs(lens[k]) - 1 && nsegs(lens[k]) > 1) begin
          peek(tg, b, d, c);
          chk("R4 not done before last segment", d, 0);
        end
        rsp(tg, s, ((k % 2) == 1 && s == nsegs(lens[k]) - 1) ? 1 : 0);
      end
      peek(tg, b, d, c);
      chk("R8 done out of order", d, 1);
      chk("R7 code", c, k % 2);
      chk("R9 pointer held", int'(cmpl_ptr), 3);
      chk("R9 no irq", int'(irq), 0);
    end
    // late response to a done entry
    rsp((3 + 14) % 16, 0, 1);
    peek((3 + 14) % 16, b, d, c);
    chk("R11 done entry code kept", c, 0);
    chk("R11 done entry still done", d, 1);

    // oldest finishes: jump by 15
    rsp(3, 0, 0);
    peek(3, b, d, c);
    chk("R8 oldest done", d, 1);
    step();
    chk("R10 pointer run jump", int'(cmpl_ptr), 2);
    chk("R10 irq on jump", int'(irq), 1);
    peek(3, b, d, c);
    chk("R10 oldest retired", b, 0);
    peek(1, b, d, c);
    chk("R10 run tail retired", b, 0);
    peek(2, b, d, c);
    chk("R10 outstanding kept", b, 1);
    step();
    chk("R10 irq single pulse", int'(irq), 0);
    for (int s = 0; s < nsegs(lens[15]); s++) rsp(2, s, 0);
    step();
    chk("R10 last retire pointer", int'(cmpl_ptr), 3);

    // retry budget of 2 on a 3-segment message
    retry_limit = 4'd2;
    issue(700, 3);
    rsp(3, 2, 2);
    chk("R5 retry valid", int'(retry_valid), 1);
    chk("R5 retry tag", int'(retry_tag), 3);
    chk("R5 retry seg", int'(retry_seg), 2);
    chk("R5 retry offset", int'(retry_offset), 512);
    chk("R5 retry last len", int'(retry_len), 700 - 512);
    step();
    chk("R5 retry one cycle", int'(retry_valid), 0);
    rsp(3, 0, 2);
    chk("R5 retry seg0 offset", int'(retry_offset), 0);
    chk("R5 retry seg0 len", int'(retry_len), 256);
    rsp(3, 1, 2);
    chk("R5 exhausted no retry", int'(retry_valid), 0);
    rsp(3, 0, 0);
    peek(3, b, d, c);
    chk("R4 pending after partial", d, 0);
    rsp(3, 2, 0);
    peek(3, b, d, c);
    chk("R4 done all segments", d, 1);
    chk("R7 retry exhausted code", c, 2);
    step();
    chk("R10 pointer after retry msg", int'(cmpl_ptr), 4);

    // retry sweep over a 16-segment message
    retry_limit = 4'd15;
    ln = 4000;
    issue(ln, 4);
    for (int s = 15; s >= 1; s--) begin
      rsp(4, s, 2);
      chk("R5 sweep valid", int'(retry_valid), 1);
      chk("R5 sweep offset", int'(retry_offset), s * 256);
      chk("R5 sweep len", int'(retry_len), (s == nsegs(ln) - 1) ? ln - s * 256 : 256);
    end
    for (int s = 0; s < 16; s++) rsp(4, s, 0);
    peek(4, b, d, c);
    chk("R4 sweep done", d, 1);
    chk("R7 sweep code ok", c, 0);
    step();
    chk("R10 pointer after sweep", int'(cmpl_ptr), 5);

    // response to an idle tag
    rsp_valid = 1'b1;
    rsp_tag = 4'd9;
    rsp_seg = 4'd0;
    rsp_status = 2'd2;
    #1;
    chk("R3 response blocks issue", int'(issue_ready), 0);
    step();
    rsp_valid = 1'b0;
    #1;
    chk("R11 idle tag no retry", int'(retry_valid), 0);
    peek(9, b, d, c);
    chk("R11 idle tag stays idle", b, 0);
    chk("R11 pointer unchanged", int'(cmpl_ptr), 5);
    chk("R3 issue ready again", int'(issue_ready), 1);

    // timeout of 5 cycles
    tmo_limit = 16'd5;
    issue(300, 5);
    for (int i = 1; i <= 3; i++) begin
      step();
      peek(5, b, d, c);
      chk("R6 not yet timed out", d, 0);
    end
    step();
    chk("R3 timeout blocks issue", int'(issue_ready), 0);
    peek(5, b, d, c);
    chk("R6 not yet timed out", d, 0);
    step();
    peek(5, b, d, c);
    chk("R6 timed out", d, 1);
    chk("R7 timeout code", c, 3);
    step();
    chk("R10 pointer after timeout", int'(cmpl_ptr), 6);
    chk("R10 irq after timeout", int'(irq), 1);

    // a response restarts the timer
    issue(300, 6);
    repeat (3) step();
    rsp(6, 0, 0);
    for (int i = 1; i <= 4; i++) begin
      step();
      peek(6, b, d, c);
      chk("R6 restarted timer", d, 0);
    end
    step();
    peek(6, b, d, c);
    chk("R6 timed out after restart", d, 1);
    chk("R7 timeout overrides ok", c, 3);
    step();
    chk("R10 pointer after restart", int'(cmpl_ptr), 7);

    // timeout disabled
    tmo_limit = 16'd0;
    issue(10, 7);
    repeat (40) step();
    peek(7, b, d, c);
    chk("R6 zero disables timeout", d, 0);
    rsp(7, 0, 0);
    step();
    chk("R10 pointer final", int'(cmpl_ptr), 8);

    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule